// File: doc/BRIEF.md
# Dual-Core Level Interrupt Aggregator

This block gathers a word of level-sensitive, active-high interrupt requests and turns them into four outputs: one ordinary interrupt line and one machine-check line for each of two processor cores. Every output has its own 32-bit enable mask. An output is high whenever at least one source that its mask enables is high. Nothing is latched, so no acknowledge is needed. A request goes away when the device that raised it drops its line.

A host reaches the block through a small 32-bit register bus with an address, a write strobe, write data, a read strobe and read data. The host can read the live source levels and read or write the four masks. A dedicated register names the highest-numbered source that is pending and enabled for core 0, which lets the core's handler pick a source to service without scanning. Only the lower 17 source positions are wired to devices. The upper ones read as zero and never raise anything.

Top module: `level_irq_aggregator`

## Requirements
- R1: After reset all four masks read back as zero, all four outputs are low, and the pending-index register reads 0x8000_0000.
- R2: A read at byte offset 0x00 returns the current source levels in bits 0..16, with bits 17..31 zero. Writes to this offset change nothing.
- R3: Byte offsets 0x10 and 0x14 hold the ordinary-interrupt masks of core 0 and core 1. Offsets 0x18 and 0x1C hold the machine-check masks of core 0 and core 1. Each reads back the full 32-bit value last written to it.
- R4: Each output equals the OR over sources of (source level AND mask bit, 1 = enabled). It reflects a change of a source or a mask one clock edge after that change is registered.
- R5: A source enabled in several masks drives every matching output at the same time.
- R6: No request is held. When all enabled sources fall, the output is low one clock later, with no acknowledge access.
- R7: A read at offset 0x20 returns, in bits 4:0, the index of the highest-numbered source that is both high and enabled in the core-0 ordinary mask. Bit 31 is 0 when such a source exists and 1 when none does. All other bits are zero.
- R8: Reads from any other offset, including offsets that are not word-aligned, return zero. Writes to offsets 0x00, 0x20 or any unmapped offset leave all masks and outputs unchanged.
- R9: Source inputs 17..31 never assert an output and never appear in the pending index, whatever the masks hold.
- R10: Read data is registered. It shows the addressed value on the clock edge that samples the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| srcLevel | input | 32 | Live interrupt source levels, active high |
| coreIrq | output | 2 | Ordinary interrupt line per core |
| coreMchk | output | 2 | Machine-check line per core |

## Verification
A mask register that holds a wrong bit shows up in two places. The mask read-back returns the wrong value, and the affected output goes wrong one edge after a source on that bit changes. For this reason the bench both reads every mask back and drives random source words against random masks. A faulty address decode either corrupts a mask that a later read exposes or returns non-zero data from an unmapped offset. A wrong priority scan gives a wrong index on the next read of offset 0x20. Random patterns and a directed case that covers the top live source both test the scan.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2,
    RD_PEND   = 2'd3
  } rdSel_e;

  localparam int unsigned MASK_CNT = 4;

  typedef struct packed {
    logic [MASK_CNT-1:0] maskWr;
    logic                rdStb;
    rdSel_e              rdSel;
    logic [1:0]          rdMaskIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CORE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_IRQ    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_MCHK   = ADDR_W'(8'h10 + 4 * NUM_CORE);
  localparam logic [ADDR_W-1:0] OFS_PEND   = ADDR_W'(8'h20);

  logic [MASK_CNT-1:0] maskHit;

  // One decode line per mask register: ordinary masks first, then machine-check.
  for (genvar m = 0; m < MASK_CNT; m++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFS =
      (m < NUM_CORE) ? ADDR_W'(OFS_IRQ + 4 * m) : ADDR_W'(OFS_MCHK + 4 * (m - NUM_CORE));
    assign maskHit[m] = (busAddr == OFS);
  end

  always_comb begin
    strobe           = '0;
    strobe.rdStb     = busRdEn;
    strobe.rdSel     = RD_NONE;
    strobe.rdMaskIdx = '0;
    if (busWrEn) strobe.maskWr = maskHit;
    if (busAddr == OFS_STATUS)    strobe.rdSel = RD_STATUS;
    else if (busAddr == OFS_PEND) strobe.rdSel = RD_PEND;
    else begin
      for (int m = 0; m < MASK_CNT; m++) begin
        if (maskHit[m]) begin
          strobe.rdSel     = RD_MASK;
          strobe.rdMaskIdx = 2'(m);
        end
      end
    end
  end

  // R3: the decode never selects two mask registers at once
  assert_onehot_wr_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.maskWr));

  // R8: the status and pending offsets never produce a mask write
  assert_ro_nowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_STATUS || busAddr == OFS_PEND) |-> strobe.maskWr == '0);

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_LIVE = 17,
  parameter int unsigned NUM_CORE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CORE-1:0] coreIrq,
  output logic [NUM_CORE-1:0] coreMchk
);

  localparam int unsigned IDX_W = $clog2(NUM_SRC);
  localparam logic [NUM_SRC-1:0] LIVE_MASK =
    (NUM_LIVE >= NUM_SRC) ? '1 : NUM_SRC'((64'd1 << NUM_LIVE) - 64'd1);

  logic [MASK_CNT-1:0][NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0]  liveSrc;
  logic [MASK_CNT-1:0] hitVec;
  logic [IDX_W-1:0]    pendIdx;
  logic                pendAny;
  logic [DATA_W-1:0]   rdNext;

  assign liveSrc = srcLevel & LIVE_MASK;

  // Mask storage, one register per output
  for (genvar m = 0; m < MASK_CNT; m++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 maskReg[m] <= '0;
      else if (strobe.maskWr[m]) maskReg[m] <= NUM_SRC'(wrData);
    end
    assign hitVec[m] = |(liveSrc & maskReg[m]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreIrq  <= '0;
      coreMchk <= '0;
    end else begin
      coreIrq  <= hitVec[NUM_CORE-1:0];
      coreMchk <= hitVec[MASK_CNT-1:NUM_CORE];
    end
  end

  // Upward scan: the last hit wins, giving the highest-numbered source
  always_comb begin
    pendIdx = '0;
    pendAny = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (liveSrc[i] && maskReg[0][i]) begin
        pendIdx = IDX_W'(i);
        pendAny = 1'b1;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strobe.rdSel)
      RD_STATUS: rdNext = DATA_W'(liveSrc);
      RD_MASK:   rdNext = DATA_W'(maskReg[strobe.rdMaskIdx]);
      RD_PEND: begin
        rdNext[IDX_W-1:0]  = pendIdx;
        rdNext[DATA_W-1]   = ~pendAny;
      end
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdStb) rdData <= rdNext;
  end

  // R1: outputs are quiet in the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (coreIrq == '0 && coreMchk == '0));

  // R7: core-0 ordinary line follows the priority scan's pending flag
  assert_pend_line_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> coreIrq[0] == $past(pendAny));

  // R6: with no source high, every output is low one edge later
  assert_level_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (srcLevel == '0) |=> (coreIrq == '0 && coreMchk == '0));

  // R8: masks hold whenever no mask write is decoded
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskWr == '0) |=> $stable(maskReg));

  // R10: read data holds between reads
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdStb |=> $stable(rdData));

  if (NUM_LIVE < NUM_SRC) begin : g_rsv
    // R9: reserved sources never show in the status word
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rdStb && strobe.rdSel == RD_STATUS) |=> rdData[NUM_SRC-1:NUM_LIVE] == '0);
  end

endmodule

// File: rtl/level_irq_aggregator.sv
module level_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_LIVE = 17,
  parameter int unsigned NUM_CORE = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic                busRdEn,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_SRC-1:0]  srcLevel,
  output logic [NUM_CORE-1:0] coreIrq,
  output logic [NUM_CORE-1:0] coreMchk
);

  ctrlStrobe_t strobe;

  irq_agg_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_CORE (NUM_CORE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  irq_agg_datapath #(
    .DATA_W   (DATA_W),
    .NUM_SRC  (NUM_SRC),
    .NUM_LIVE (NUM_LIVE),
    .NUM_CORE (NUM_CORE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .srcLevel (srcLevel),
    .rdData   (busRdData),
    .coreIrq  (coreIrq),
    .coreMchk (coreMchk)
  );

endmodule

// File: tb/level_irq_aggregator_tb.sv
module level_irq_aggregator_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LIVE = 32'h0001_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [31:0] srcLevel = '0;
  logic [1:0]  coreIrq, coreMchk;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] msk [4];
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  level_irq_aggregator u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .srcLevel(srcLevel), .coreIrq(coreIrq), .coreMchk(coreMchk));

  function automatic logic [7:0] maskOfs(int m);
    return (m < 2) ? 8'(8'h10 + 4*m) : 8'(8'h18 + 4*(m-2));
  endfunction

  function automatic logic [3:0] expOut(logic [31:0] s);
    logic [3:0] r;
    for (int m = 0; m < 4; m++) r[m] = |(s & LIVE & msk[m]);
    return r;
  endfunction

  function automatic logic [31:0] expPend(logic [31:0] s);
    logic [31:0] act = s & LIVE & msk[0];
    for (int i = 31; i >= 0; i--)
      if (act[i]) return 32'(i);
    return 32'h8000_0000;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic setMasks(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] e);
    msk[0] = a; msk[1] = b; msk[2] = c; msk[3] = e;
    for (int m = 0; m < 4; m++) wr(maskOfs(m), msk[m]);
  endtask

  task automatic checkOuts(string req);
    check(req, {28'd0, coreMchk, coreIrq}, {28'd0, expOut(srcLevel)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int m = 0; m < 4; m++) msk[m] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 outputs", {28'd0, coreMchk, coreIrq}, 32'd0);
    for (int m = 0; m < 4; m++) begin
      rdReg(maskOfs(m), rd);
      check("R1 mask", rd, 32'd0);
    end
    rdReg(8'h20, rd);
    check("R1 pend", rd, 32'h8000_0000);

    // R3: read-back of each mask
    setMasks(32'hA5A5_0F0F, 32'h1234_5678, 32'hFFFF_0001, 32'h8000_0002);
    for (int m = 0; m < 4; m++) begin
      rdReg(maskOfs(m), rd);
      check("R3 readback", rd, msk[m]);
    end

    // R5: one source in all masks raises every output
    setMasks(32'h8, 32'h8, 32'h8, 32'h8);
    srcLevel = 32'h8;
    @(negedge clk);
    check("R5 all outputs", {28'd0, coreMchk, coreIrq}, 32'hF);

    // R6: drop source, outputs low one edge later
    srcLevel = 32'h0;
    @(negedge clk);
    check("R6 drop", {28'd0, coreMchk, coreIrq}, 32'h0);

    // R9: reserved sources have no effect
    setMasks('1, '1, '1, '1);
    srcLevel = 32'hFFFE_0000;
    @(negedge clk);
    check("R9 outputs", {28'd0, coreMchk, coreIrq}, 32'h0);
    rdReg(8'h00, rd);
    check("R9 status", rd, 32'h0);
    rdReg(8'h20, rd);
    check("R9 pend", rd, 32'h8000_0000);

    // R7: highest live index wins
    srcLevel = 32'hFFFF_0204;
    rdReg(8'h20, rd);
    check("R7 top live", rd, 32'd16);

    // R2: status read
    rdReg(8'h00, rd);
    check("R2 status", rd, 32'h0001_0204);

    // R10: read data holds without read strobe
    srcLevel = 32'h0000_0001;
    @(negedge clk); @(negedge clk);
    check("R10 hold", busRdData, 32'h0001_0204);

    // R8: unmapped reads and ignored writes
    rdReg(8'h04, rd);  check("R8 rd 0x04", rd, 32'h0);
    rdReg(8'h11, rd);  check("R8 rd 0x11", rd, 32'h0);
    rdReg(8'h24, rd);  check("R8 rd 0x24", rd, 32'h0);
    setMasks(32'h0000_00F0, 32'h0, 32'h0, 32'h0);
    wr(8'h00, '1); wr(8'h20, '1); wr(8'h0C, '1); wr(8'h11, '1); wr(8'h1D, '1);
    for (int m = 0; m < 4; m++) begin
      rdReg(maskOfs(m), rd);
      check("R8 mask kept", rd, msk[m]);
    end
    srcLevel = 32'h0000_0001;
    @(negedge clk);
    check("R8 outputs", {28'd0, coreMchk, coreIrq}, 32'h0);

    // R4: random masks and sources
    for (int it = 0; it < 60; it++) begin
      setMasks($urandom & $urandom, $urandom & $urandom, $urandom, $urandom & $urandom);
      srcLevel = $urandom & $urandom;
      @(negedge clk);
      checkOuts("R4 random");
      rdReg(8'h20, rd);
      check("R7 random", rd, expPend(srcLevel));
      rdReg(8'h00, rd);
      check("R2 random", rd, srcLevel & LIVE);
      // R4: change sources only, one-cycle latency
      srcLevel = $urandom;
      @(negedge clk);
      checkOuts("R4 src change");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule